// File: doc/BRIEF.md
# Serial Peripheral Master with Mode-Dependent Word Framing

This block is a synchronous serial master. It takes words from a small transmit queue, drives a serial clock, and shifts each word out on one data line while it shifts a word in on the other. An active-low select output frames the traffic. The four clock polarity and phase modes can all be chosen. In every mode the select line is high while the block is idle and goes low when a word starts. The modes differ in what the select line does between words that follow each other directly.

When the phase bit is 0, the select line rises for exactly one serial-clock period between consecutive words. During that period the serial clock stays at its idle level. When the phase bit is 1, the select line stays low for a whole run of queued words, so a multi-word command reaches the slave as one frame. A run continues only if the next word is already queued at the moment the last bit of the current word is sampled. Otherwise the frame closes, and a later word opens a new one.

The host pushes words through a valid/ready port. It chooses the mode and a divider that sets the serial half-period in system clocks. Each received word appears for one cycle together with a strobe.

Top module: `spi_framed_master`

## Requirements
- R1: With no word queued or in flight, `busy` is low, `ss_n` is high and `sclk` rests at the polarity bit `mode[1]` (low for 0, high for 1).
- R2: When a queued word starts, `ss_n` falls and stays low until that word's framing completes.
- R3: After each word that ends a frame, `ss_n` rises exactly one serial-clock period (two half-periods) after the last bit of that word is sampled.
- R4: With `mode[0]`=0 and words back to back, `ss_n` goes high for exactly one serial-clock period between words, and `sclk` does not toggle while `ss_n` is high.
- R5: With `mode[0]`=1 and words back to back, `ss_n` falls once and stays low until after the last word.
- R6: The mode encoding is `mode[1]`=polarity and `mode[0]`=phase. Modes 0 and 3 sample on the rising `sclk` edge, and modes 1 and 2 on the falling edge. `mosi` never changes at a sampling edge. With phase 0 the first bit is driven before the first edge.
- R7: Each word is `WORD_W` bits long, sent most-significant bit first, with exactly `WORD_W` sampling edges per word. Words leave in the order they were pushed.
- R8: Every `sclk` half-period lasts `clk_div` system clocks. A value of 0 is treated as 1.
- R9: After the last bit of each word is sampled, `rx_valid` pulses for one cycle. `rx_data` then holds the bits sampled from `miso`, with the first one as the MSB.
- R10: The transmit queue holds `FIFO_DEPTH` words. `tx_ready` is low exactly when the queue is full, and a full queue implies `busy`.
- R11: Words are back to back only if the next word is queued when the current word's last bit is sampled. Words pushed one at a time after the block goes idle each get their own frame, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Bit 1 = clock polarity, bit 0 = clock phase |
| clk_div | input | DIV_W | Serial half-period in system clocks (0 acts as 1) |
| tx_data | input | WORD_W | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Queue can take a word |
| rx_data | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| busy | output | 1 | A word is queued or being framed |
| sclk | output | 1 | Serial clock |
| ss_n | output | 1 | Active-low frame/select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench sweeps every mode against three divider settings, including zero. Each combination runs once as a queued burst and once as isolated single words. A monitor decodes the serial lines at the bench's own sampling edge and times the select line against the last sampled edge.

Each bug shows up differently. A design that closed the frame at the wrong moment would give a tail or gap width other than two half-periods. A design that mixed up the phase rules would either pulse the select line in phase-1 bursts or hold it low in phase-0 bursts. A wrong sampling edge or bit order would produce words that differ from those pushed. A zero divider left untreated would hang the clock generator.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_SHIFT = 2'd1,
        FS_TAIL  = 2'd2,
        FS_GAP   = 2'd3
    } fsm_e;

    function automatic logic pol_of(input logic [1:0] m);
        return m[1];
    endfunction

    function automatic logic pha_of(input logic [1:0] m);
        return m[0];
    endfunction

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    input  logic         pop,
    output logic [W-1:0] out_data,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem_q [DEPTH];
    logic full;
    logic push;

    always_comb begin
        full     = (ptr_q.wp[AW] != ptr_q.rp[AW]) &&
                   (ptr_q.wp[AW-1:0] == ptr_q.rp[AW-1:0]);
        empty    = (ptr_q.wp == ptr_q.rp);
        in_ready = !full;
        push     = in_valid && !full;
        out_data = mem_q[ptr_q.rp[AW-1:0]];
        ptr_d    = ptr_q;
        if (push) ptr_d.wp = ptr_q.wp + 1'b1;
        if (pop && !empty) ptr_d.rp = ptr_q.rp + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[ptr_q.wp[AW-1:0]] <= in_data;
    end

endmodule

// File: rtl/spi_fm_tick.sv
module spi_fm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] lim;
    } tk_t;

    tk_t tk_d, tk_q;

    always_comb begin
        tk_d = tk_q;
        tick = !idle && (tk_q.cnt == tk_q.lim - 1'b1);
        if (idle) begin
            tk_d.cnt = '0;
            tk_d.lim = (div == '0) ? DIV_W'(1) : div;
        end else if (tick) begin
            tk_d.cnt = '0;
        end else begin
            tk_d.cnt = tk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tk_q <= '{cnt: '0, lim: DIV_W'(1)};
        else        tk_q <= tk_d;
    end

endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
    import spi_fm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   mode_in,
    input  logic         q_empty,
    input  logic [W-1:0] q_data,
    output logic         pop,
    input  logic         miso,
    output logic         mosi,
    output logic         sclk,
    output logic         ss_n,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    output logic         active
);
    localparam int HW = $clog2(2 * W);
    localparam logic [HW-1:0] LAST_H  = HW'(2 * W - 1);
    localparam logic [HW-1:0] LAST_S0 = HW'(2 * W - 2);

    typedef struct packed {
        fsm_e         st;
        logic [HW-1:0] half;
        logic         left;
        logic         cont;
        logic [1:0]   mode;
        logic [W-1:0] sh;
        logic [W-1:0] rsh;
        logic         mosi;
        logic [W-1:0] rx_data;
        logic         rx_valid;
    } eng_t;

    eng_t e_d, e_q;
    logic pha, start, samp, drv, last, samp_last, more;

    always_comb begin
        e_d          = e_q;
        e_d.rx_valid = 1'b0;
        pop          = 1'b0;
        pha          = pha_of(e_q.mode);
        start        = 1'b0;
        samp         = 1'b0;
        drv          = 1'b0;
        last         = 1'b0;
        samp_last    = 1'b0;
        more         = !q_empty;
        unique case (e_q.st)
            FS_IDLE: begin
                e_d.mode = mode_in;
                pha      = pha_of(mode_in);
                start    = more;
            end
            FS_SHIFT: if (tick) begin
                last      = (e_q.half == LAST_H);
                samp      = pha ? e_q.half[0] : !e_q.half[0];
                drv       = pha ? !e_q.half[0] : (e_q.half[0] && !last);
                samp_last = samp && (e_q.half == (pha ? LAST_H : LAST_S0));
                e_d.half  = e_q.half + 1'b1;
                if (samp) e_d.rsh = {e_q.rsh[W-2:0], miso};
                if (samp_last) begin
                    e_d.rx_data  = {e_q.rsh[W-2:0], miso};
                    e_d.rx_valid = 1'b1;
                    e_d.cont     = more;
                end
                if (drv) begin
                    e_d.mosi = e_q.sh[W-1];
                    e_d.sh   = {e_q.sh[W-2:0], 1'b0};
                end
                if (last) begin
                    if (pha && more) begin
                        start = 1'b1;
                    end else begin
                        e_d.st   = FS_TAIL;
                        e_d.left = pha;
                    end
                end
            end
            FS_TAIL: if (tick) begin
                if (e_q.left) begin
                    e_d.left = 1'b0;
                end else if (!pha && e_q.cont) begin
                    e_d.st   = FS_GAP;
                    e_d.left = 1'b1;
                end else begin
                    e_d.st = FS_IDLE;
                end
            end
            FS_GAP: if (tick) begin
                if (e_q.left) e_d.left = 1'b0;
                else          start    = 1'b1;
            end
            default: e_d.st = FS_IDLE;
        endcase
        if (start) begin
            pop      = 1'b1;
            e_d.st   = FS_SHIFT;
            e_d.half = '0;
            if (!pha) begin
                e_d.mosi = q_data[W-1];
                e_d.sh   = {q_data[W-2:0], 1'b0};
            end else begin
                e_d.sh = q_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{st: FS_IDLE, half: '0, left: 1'b0, cont: 1'b0, mode: 2'b00,
                     sh: '0, rsh: '0, mosi: 1'b0, rx_data: '0, rx_valid: 1'b0};
        end else begin
            e_q <= e_d;
        end
    end

    assign sclk     = pol_of(e_q.mode) ^ ((e_q.st == FS_SHIFT) && e_q.half[0]);
    assign ss_n     = (e_q.st == FS_IDLE) || (e_q.st == FS_GAP);
    assign mosi     = e_q.mosi;
    assign rx_data  = e_q.rx_data;
    assign rx_valid = e_q.rx_valid;
    assign active   = (e_q.st != FS_IDLE);

endmodule

// File: rtl/spi_framed_master.sv
module spi_framed_master #(
    parameter int WORD_W     = 8,
    parameter int FIFO_DEPTH = 4,
    parameter int DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              busy,
    output logic              sclk,
    output logic              ss_n,
    output logic              mosi,
    input  logic              miso
);
    logic              q_empty;
    logic [WORD_W-1:0] q_data;
    logic              pop;
    logic              tick;
    logic              active;

    spi_fm_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
        .pop(pop), .out_data(q_data), .empty(q_empty)
    );

    spi_fm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .idle(!active), .div(clk_div), .tick(tick)
    );

    spi_fm_engine #(.W(WORD_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_in(mode),
        .q_empty(q_empty), .q_data(q_data), .pop(pop),
        .miso(miso), .mosi(mosi), .sclk(sclk), .ss_n(ss_n),
        .rx_data(rx_data), .rx_valid(rx_valid), .active(active)
    );

    assign busy = active || !q_empty;

endmodule

// File: rtl/spi_framed_master_chk.sv
module spi_framed_master_chk #(
    parameter int WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              tx_ready,
    input logic              rx_valid,
    input logic              busy,
    input logic              sclk,
    input logic              ss_n,
    input logic              mosi
);
    // R1
    idle_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ss_n);

    // R1
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && $stable(mode)) |-> (sclk == mode[1]));

    // R4
    gap_sclk_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ss_n && $past(busy && ss_n) && $stable(mode)) |-> $stable(sclk));

    // R6
    sample_mosi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ss_n && !$stable(sclk) && (sclk == !(mode[1] ^ mode[0])) && $stable(mode))
            |-> $stable(mosi));

    // R9
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10
    full_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ready |-> busy);

endmodule

bind spi_framed_master spi_framed_master_chk #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .busy(busy), .sclk(sclk), .ss_n(ss_n), .mosi(mosi)
);

// File: tb/sim_spi_framed_master.sv
`timescale 1ns/1ps
module sim_spi_framed_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [3:0] clk_div = 4'd1;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       busy;
    logic       sclk;
    logic       ss_n;
    logic       mosi;
    logic       miso;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] sent [16];
    logic [7:0] cap  [16];
    logic [7:0] rxw  [16];
    logic [7:0] mon_sh = 8'h00;
    int  cap_n = 0, mon_n = 0, rx_n = 0, falls = 0, tail_n = 0, tail_bad = 0;
    int  gap_n = 0, gap_bad = 0, per_bad = 0, edge_err = 0;
    bit  armed = 0, have_rise = 0, full_seen = 0;
    time t_last = 0, t_rise = 0;
    time exp_half = 20;

    always #10 clk = ~clk;

    assign miso = ~mosi;

    spi_framed_master #(.WORD_W(8), .FIFO_DEPTH(4), .DIV_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(cfg_mode), .clk_div(clk_div),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy),
        .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .miso(miso)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Slave-side monitor: decode mosi at the sampling edge of the current mode
    always @(sclk) begin
        if (armed && ss_n === 1'b0 && sclk === ~(cfg_mode[1] ^ cfg_mode[0])) begin
            if (mon_n != 0 && ($time - t_last) != 2 * exp_half) per_bad++;
            t_last = $time;
            mon_sh = {mon_sh[6:0], mosi};
            mon_n++;
            if (mon_n == 8) begin
                if (cap_n < 16) cap[cap_n] = mon_sh;
                cap_n++;
                mon_n = 0;
            end
        end
        if (armed && ss_n === 1'b1 && busy === 1'b1) edge_err++;
    end

    always @(negedge ss_n) begin
        if (armed) begin
            falls++;
            if (have_rise) begin
                gap_n++;
                if (($time - t_rise) != 2 * exp_half) gap_bad++;
            end
        end
    end

    always @(posedge ss_n) begin
        if (armed) begin
            t_rise = $time;
            have_rise = 1;
            tail_n++;
            if (($time - t_last) != 2 * exp_half) tail_bad++;
        end
    end

    always @(negedge clk) begin
        if (armed && rx_valid === 1'b1) begin
            if (rx_n < 16) rxw[rx_n] = rx_data;
            rx_n++;
        end
    end

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = d;
        while (!tx_ready) begin
            full_seen = 1;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run(input int m, input int dv, input int n, input bit burst);
        int deff;
        bit pha;
        deff = (dv == 0) ? 1 : dv;
        pha  = m[0];
        @(negedge clk);
        cfg_mode = m[1:0];
        clk_div  = dv[3:0];
        exp_half = 20 * deff;
        repeat (4) @(negedge clk);
        chk(ss_n === 1'b1 && busy === 1'b0 && sclk === m[1], "R1 idle before run",
            {ss_n, busy, sclk}, {1'b1, 1'b0, m[1]});
        cap_n = 0; mon_n = 0; rx_n = 0; falls = 0; tail_n = 0; tail_bad = 0;
        gap_n = 0; gap_bad = 0; per_bad = 0; edge_err = 0;
        have_rise = 0; full_seen = 0; armed = 1;
        for (int i = 0; i < n; i++) begin
            sent[i] = 8'((i * 37 + m * 11 + dv * 5 + 90) & 255);
            push(sent[i]);
            if (!burst) wait_idle();
        end
        wait_idle();
        armed = 0;
        chk(cap_n == n, "R7 words seen on mosi", cap_n, n);
        for (int i = 0; i < n; i++)
            chk(cap[i] == sent[i], "R6 R7 mosi word", cap[i], sent[i]);
        chk(rx_n == n, "R9 rx strobes", rx_n, n);
        for (int i = 0; i < n; i++)
            chk(rxw[i] == ~sent[i], "R9 rx word", rxw[i], 8'(~sent[i]));
        chk(per_bad == 0, "R8 sampling edge spacing", per_bad, 0);
        chk(tail_bad == 0 && tail_n == falls, "R3 tail width", tail_bad, 0);
        chk(edge_err == 0, "R4 sclk quiet while deselected", edge_err, 0);
        if (burst && pha)
            chk(falls == 1, "R5 one frame for phase-1 burst", falls, 1);
        else if (burst)
            chk(falls == n && gap_n == n - 1 && gap_bad == 0, "R4 R2 gap per word", falls, n);
        else
            chk(falls == n, "R11 R2 separate frames", falls, n);
        if (burst) chk(full_seen == 1, "R10 ready drops when full", full_seen, 1);
        chk(ss_n === 1'b1 && sclk === m[1], "R1 idle after run", {ss_n, sclk}, {1'b1, m[1]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ss_n === 1'b1 && busy === 1'b0 && tx_ready === 1'b1 && rx_valid === 1'b0,
            "R1 reset state", {ss_n, busy, tx_ready, rx_valid}, 4'b1010);
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 3; k++) begin
                run(m, (k == 0) ? 0 : (k == 1) ? 1 : 3, 6, 1'b1);
                run(m, (k == 0) ? 0 : (k == 1) ? 1 : 3, 3, 1'b0);
            end
        end
        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule